// File: doc/BRIEF.md
# Tightly Coupled Memory Address Router

This block sits on the data port of a processor core. It steers every byte, halfword or word load and store to one of three places. Two places are local RAM banks, an instruction bank and a data bank. The third is the external system bus. Three control inputs set the windows of the two banks. The instruction window always starts at address zero and its length is programmable. The data window has a programmable start address and a programmable length.

An access that falls in neither window is passed to the external bus unchanged, with a valid/ready handshake. An access that falls in a window is served locally. A local store completes in the same cycle. A local load returns its data one cycle later. Each bank holds fewer bytes than its window can cover. The offset into a bank is therefore wrapped, so the stored contents repeat across a window that is larger than the bank. The bank sizes are parameters. The production setting is 32 KB for the instruction bank and 16 KB for the data bank. The defaults are smaller so that the block elaborates quickly.

Top module: `tcm_addr_router`

## Requirements
- R1: An access with `req_addr < itcm_size` (unsigned) hits the instruction bank. When `itcm_size` is zero the instruction bank never hits.
- R2: An access hits the data bank when `dtcm_base <= req_addr` and `req_addr < dtcm_base + dtcm_size`. The sum is formed without 32-bit wrap-around. With `dtcm_base` all ones and `dtcm_size` zero, the data bank never hits.
- R3: When both windows contain an address, the instruction bank wins. Either bank wins over the external bus.
- R4: The instruction bank is indexed by `req_addr[ITCM_OFS_W-1:0]`, so its contents repeat every 2^ITCM_OFS_W bytes.
- R5: The data bank is indexed by `(req_addr - dtcm_base)[DTCM_OFS_W-1:0]`, so its contents repeat every 2^DTCM_OFS_W bytes above the base.
- R6: `req_size` encodes 0 = byte, 1 = halfword, 2 or 3 = word.
  - A byte store writes only lane `offset[1:0]`, using `req_wdata[7:0]`.
  - A halfword store writes lanes 1:0 when `offset[1]` is 0 and lanes 3:2 otherwise, using `req_wdata[15:0]`. `offset[0]` is ignored.
  - A word store writes all four lanes and ignores `offset[1:0]`.
  - Lanes that are not addressed keep their contents.
- R7: A local load raises `rsp_valid` for exactly one cycle, on the cycle after the request. The data is right-aligned and zero-extended, using the same lane selection as R6. A local store produces no response.
- R8: Forwarding to the external bus:
  - An access with no local hit drives `ext_valid` with `ext_write`, `ext_size`, `ext_addr` and `ext_wdata` equal to the request fields.
  - In that case `req_ready` follows `ext_ready`.
  - A local hit keeps `ext_valid` low and drives `req_ready` high.
- R9: `ext_rvalid` and `ext_rdata` appear on `rsp_valid` and `rsp_rdata` in the same cycle.
- R10: `rst_n` asserts asynchronously and releases through a two-stage synchronizer. While the block is in reset, no local response is produced and no request is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| itcm_size | input | 32 | Length of the instruction window starting at zero |
| dtcm_base | input | 32 | Start address of the data window |
| dtcm_size | input | 32 | Length of the data window |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data, right-aligned |
| ext_valid | output | 1 | Forwarded request valid |
| ext_ready | input | 1 | External bus accepts |
| ext_write | output | 1 | Forwarded store flag |
| ext_size | output | 2 | Forwarded size |
| ext_addr | output | 32 | Forwarded address |
| ext_wdata | output | 32 | Forwarded store data |
| ext_rvalid | input | 1 | External load data valid |
| ext_rdata | input | 32 | External load data |

## Verification
The bench first fills both banks with word stores. It then mixes byte, halfword and word stores and loads at every lane offset. This separates correct lane strobes and read alignment from whole-word behaviour.

Window boundaries are probed one byte inside and one byte outside each edge. Overlapping windows are probed to check the priority order. Windows larger than their banks are probed to check wrapping. A zero instruction size and an all-ones data base are probed to check that each bank can be disabled. A data window that would wrap past the top of the address space is probed to check the overflow-free compare.

Accesses that miss both windows are checked for field-for-field forwarding and for `req_ready` following `ext_ready`, including with the external bus stalled.

// File: rtl/tcmr_pkg.sv
package tcmr_pkg;
  typedef enum logic [1:0] {
    RT_EXT  = 2'd0,
    RT_ITCM = 2'd1,
    RT_DTCM = 2'd2
  } route_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
endpackage

// File: rtl/tcmr_decode.sv
module tcmr_decode
  import tcmr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] itcm_size,
  input  logic [ADDR_W-1:0] dtcm_base,
  input  logic [ADDR_W-1:0] dtcm_size,
  output route_e            route,
  output logic [ADDR_W-1:0] dtcm_ofs
);
  logic [ADDR_W:0] win_end;
  logic            in_itcm;
  logic            in_dtcm;

  always_comb begin
    // one extra bit so a window near the top of memory does not wrap
    win_end  = {1'b0, dtcm_base} + {1'b0, dtcm_size};
    in_itcm  = addr < itcm_size;
    in_dtcm  = (addr >= dtcm_base) && ({1'b0, addr} < win_end);
    dtcm_ofs = addr - dtcm_base;
    if (in_itcm)      route = RT_ITCM;
    else if (in_dtcm) route = RT_DTCM;
    else              route = RT_EXT;
  end
endmodule

// File: rtl/tcmr_lanes.sv
module tcmr_lanes
  import tcmr_pkg::*;
(
  input  logic [1:0]        wr_size,
  input  logic [1:0]        wr_lo,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_strb,
  output logic [DATA_W-1:0] wr_word,
  input  logic [1:0]        rd_size,
  input  logic [1:0]        rd_lo,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_shift;

  always_comb begin
    case (wr_size)
      SZ_BYTE: begin
        wr_strb = 4'b0001 << wr_lo;
        wr_word = {4{wr_data[7:0]}};
      end
      SZ_HALF: begin
        wr_strb = wr_lo[1] ? 4'b1100 : 4'b0011;
        wr_word = {2{wr_data[15:0]}};
      end
      default: begin
        wr_strb = 4'b1111;
        wr_word = wr_data;
      end
    endcase
  end

  always_comb begin
    rd_shift = rd_word >> {rd_lo, 3'b000};
    case (rd_size)
      SZ_BYTE: rd_data = {24'd0, rd_shift[7:0]};
      SZ_HALF: rd_data = rd_lo[1] ? {16'd0, rd_word[31:16]} : {16'd0, rd_word[15:0]};
      default: rd_data = rd_word;
    endcase
  end
endmodule

// File: rtl/tcmr_bank.sv
module tcmr_bank
  import tcmr_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  strb,
  input  logic [OFS_W-3:0]  idx,
  input  logic [DATA_W-1:0] wword,
  output logic [DATA_W-1:0] rword
);
  localparam int WORDS = 1 << (OFS_W - 2);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] rbyte_q;

    always_ff @(posedge clk) begin
      if (en && we && strb[g]) mem[idx] <= wword[8*g +: 8];
      if (en && !we)           rbyte_q  <= mem[idx];
    end

    assign rword[8*g +: 8] = rbyte_q;
  end
endmodule

// File: rtl/tcm_addr_router.sv
module tcm_addr_router
  import tcmr_pkg::*;
#(
  parameter int ITCM_OFS_W = 12,
  parameter int DTCM_OFS_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] itcm_size,
  input  logic [31:0] dtcm_base,
  input  logic [31:0] dtcm_size,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        ext_valid,
  input  logic        ext_ready,
  output logic        ext_write,
  output logic [1:0]  ext_size,
  output logic [31:0] ext_addr,
  output logic [31:0] ext_wdata,
  input  logic        ext_rvalid,
  input  logic [31:0] ext_rdata
);
  localparam int IIDX_W = ITCM_OFS_W - 2;
  localparam int DIDX_W = DTCM_OFS_W - 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  route_e            route;
  logic [ADDR_W-1:0] dtcm_ofs;
  logic              go;
  logic [1:0]        acc_lo;
  logic [LANES-1:0]  strb;
  logic [DATA_W-1:0] wword;
  logic [DATA_W-1:0] i_rword;
  logic [DATA_W-1:0] d_rword;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] tcm_rdata;
  logic              i_en;
  logic              d_en;

  logic       rd_pend_d, rd_pend_q;
  logic       rd_dsel_d, rd_dsel_q;
  logic [1:0] rd_size_d, rd_size_q;
  logic [1:0] rd_lo_d,   rd_lo_q;
  logic       unused_bits;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tcmr_decode u_decode (
    .addr      (req_addr),
    .itcm_size (itcm_size),
    .dtcm_base (dtcm_base),
    .dtcm_size (dtcm_size),
    .route     (route),
    .dtcm_ofs  (dtcm_ofs)
  );

  assign go     = req_valid && rst_sync_n;
  assign acc_lo = (route == RT_ITCM) ? req_addr[1:0] : dtcm_ofs[1:0];
  assign i_en   = go && (route == RT_ITCM);
  assign d_en   = go && (route == RT_DTCM);

  tcmr_lanes u_lanes (
    .wr_size (req_size),
    .wr_lo   (acc_lo),
    .wr_data (req_wdata),
    .wr_strb (strb),
    .wr_word (wword),
    .rd_size (rd_size_q),
    .rd_lo   (rd_lo_q),
    .rd_word (rd_word),
    .rd_data (tcm_rdata)
  );

  tcmr_bank #(.OFS_W(ITCM_OFS_W)) u_ibank (
    .clk   (clk),
    .en    (i_en),
    .we    (req_write),
    .strb  (strb),
    .idx   (req_addr[ITCM_OFS_W-1:2]),
    .wword (wword),
    .rword (i_rword)
  );

  tcmr_bank #(.OFS_W(DTCM_OFS_W)) u_dbank (
    .clk   (clk),
    .en    (d_en),
    .we    (req_write),
    .strb  (strb),
    .idx   (dtcm_ofs[DTCM_OFS_W-1:2]),
    .wword (wword),
    .rword (d_rword)
  );

  // next state of the load-response tracker
  always_comb begin
    rd_pend_d = go && !req_write && (route != RT_EXT);
    rd_dsel_d = rd_dsel_q;
    rd_size_d = rd_size_q;
    rd_lo_d   = rd_lo_q;
    if (rd_pend_d) begin
      rd_dsel_d = (route == RT_DTCM);
      rd_size_d = req_size;
      rd_lo_d   = acc_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_pend_q <= 1'b0;
      rd_dsel_q <= 1'b0;
      rd_size_q <= 2'd0;
      rd_lo_q   <= 2'd0;
    end else begin
      rd_pend_q <= rd_pend_d;
      rd_dsel_q <= rd_dsel_d;
      rd_size_q <= rd_size_d;
      rd_lo_q   <= rd_lo_d;
    end
  end

  assign rd_word   = rd_dsel_q ? d_rword : i_rword;
  assign rsp_valid = rd_pend_q || ext_rvalid;
  assign rsp_rdata = rd_pend_q ? tcm_rdata : ext_rdata;

  assign ext_valid = go && (route == RT_EXT);
  assign req_ready = (route == RT_EXT) ? (ext_ready && rst_sync_n) : 1'b1;
  assign ext_write = req_write;
  assign ext_size  = req_size;
  assign ext_addr  = req_addr;
  assign ext_wdata = req_wdata;

  assign unused_bits = ^{req_addr[ADDR_W-1:ITCM_OFS_W], dtcm_ofs[ADDR_W-1:DTCM_OFS_W],
                         IIDX_W[0], DIDX_W[0]};
endmodule

// File: rtl/tcmr_checker.sv
module tcmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic [31:0] itcm_size,
  input logic [31:0] dtcm_base,
  input logic [31:0] dtcm_size,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        ext_valid,
  input logic [31:0] ext_addr,
  input logic        ext_rvalid
);
  logic i_hit, d_hit, local_rd;

  always_comb begin
    i_hit    = req_addr < itcm_size;
    d_hit    = (req_addr >= dtcm_base) &&
               ({1'b0, req_addr} < ({1'b0, dtcm_base} + {1'b0, dtcm_size}));
    local_rd = req_valid && !req_write && (i_hit || d_hit);
  end

  a_r1_itcm_keeps_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && i_hit) |-> !ext_valid);

  a_r2_dtcm_keeps_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && d_hit) |-> !ext_valid);

  a_r8_miss_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !i_hit && !d_hit) |-> (ext_valid && ext_addr == req_addr));

  a_r8_local_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (i_hit || d_hit)) |-> req_ready);

  a_r7_local_load_answers: assert property (@(posedge clk) disable iff (!rst_n)
    local_rd |=> rsp_valid);

  a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(local_rd) || ext_rvalid));
endmodule

bind tcm_addr_router tcmr_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .itcm_size  (itcm_size),
  .dtcm_base  (dtcm_base),
  .dtcm_size  (dtcm_size),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ext_valid  (ext_valid),
  .ext_addr   (ext_addr),
  .ext_rvalid (ext_rvalid)
);

// File: tb/tcm_addr_router_tb.sv
`timescale 1ns/1ps
module tcm_addr_router_tb_top;
  localparam int IOFS = 12;
  localparam int DOFS = 11;
  localparam int IBYTES = 1 << IOFS;
  localparam int DBYTES = 1 << DOFS;

  logic        clk;
  logic        rst_n;
  logic [31:0] itcm_size, dtcm_base, dtcm_size;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        ext_valid, ext_ready, ext_write;
  logic [1:0]  ext_size;
  logic [31:0] ext_addr, ext_wdata;
  logic        ext_rvalid;
  logic [31:0] ext_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] im [IBYTES];
  logic [7:0] dm [DBYTES];

  tcm_addr_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .itcm_size(itcm_size), .dtcm_base(dtcm_base), .dtcm_size(dtcm_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_write(ext_write),
    .ext_size(ext_size), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not end, act=hung exp=done");
    report();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // 0 = external, 1 = instruction bank, 2 = data bank
  function automatic int model_route(input logic [31:0] a);
    logic [32:0] e;
    e = {1'b0, dtcm_base} + {1'b0, dtcm_size};
    if (a < itcm_size) return 1;
    if (a >= dtcm_base && {1'b0, a} < e) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] model_word(input int rt, input logic [31:0] ofs);
    logic [31:0] w;
    for (int l = 0; l < 4; l++) begin
      if (rt == 1) w[8*l +: 8] = im[((ofs % IBYTES) & ~32'd3) + l];
      else         w[8*l +: 8] = dm[((ofs % DBYTES) & ~32'd3) + l];
    end
    return w;
  endfunction

  task automatic access(input bit w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input string tag);
    int rt;
    logic [31:0] ofs, wrd, exp;
    logic [3:0] st;
    logic [31:0] bw;
    rt  = model_route(a);
    ofs = (rt == 2) ? a - dtcm_base : a;
    wrd = model_word(rt, ofs);
    case (sz)
      2'd0: begin st = 4'b0001 << ofs[1:0]; bw = {4{wd[7:0]}};
                  exp = (wrd >> (8 * ofs[1:0])) & 32'hFF; end
      2'd1: begin st = ofs[1] ? 4'b1100 : 4'b0011; bw = {2{wd[15:0]}};
                  exp = ofs[1] ? {16'd0, wrd[31:16]} : {16'd0, wrd[15:0]}; end
      default: begin st = 4'b1111; bw = wd; exp = wrd; end
    endcase
    req_write = w; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    #1;
    chk(ext_valid == (rt == 0), {tag, " R8 ext_valid"}, 32'(ext_valid), 32'(rt == 0));
    if (rt == 0) begin
      chk(req_ready == ext_ready, {tag, " R8 req_ready"}, 32'(req_ready), 32'(ext_ready));
      chk(ext_addr == a && ext_wdata == wd && ext_write == w && ext_size == sz,
          {tag, " R8 fields"}, ext_addr, a);
    end else begin
      chk(req_ready == 1'b1, {tag, " R8 local ready"}, 32'(req_ready), 32'd1);
    end
    @(posedge clk);
    if (w && rt != 0) begin
      for (int l = 0; l < 4; l++) begin
        if (st[l]) begin
          if (rt == 1) im[((ofs % IBYTES) & ~32'd3) + l] = bw[8*l +: 8];
          else         dm[((ofs % DBYTES) & ~32'd3) + l] = bw[8*l +: 8];
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (!w && rt != 0) begin
      chk(rsp_valid == 1'b1, {tag, " R7 rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk(rsp_rdata == exp, {tag, " R7 rdata"}, rsp_rdata, exp);
    end else begin
      chk(rsp_valid == 1'b0, {tag, " R7 no rsp"}, 32'(rsp_valid), 32'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = 32'd0; req_wdata = 32'd0; ext_ready = 1'b1; ext_rvalid = 1'b0;
    ext_rdata = 32'd0; itcm_size = 32'h8000; dtcm_base = 32'h0080_0000; dtcm_size = 32'h4000;
    repeat (3) @(negedge clk);
    // R10: held in reset, a request must not be forwarded or answered
    req_valid = 1'b1; req_addr = 32'h0100_0000; #1;
    chk(ext_valid == 1'b0, "R10 no forward in reset", 32'(ext_valid), 32'd0);
    chk(rsp_valid == 1'b0, "R10 no rsp in reset", 32'(rsp_valid), 32'd0);
    req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && ext_valid == 1'b0, "R10 reset state", 32'(rsp_valid), 32'd0);
    repeat (3) @(negedge clk);

    // fill both banks so every later load has a defined model value
    for (int i = 0; i < IBYTES / 4; i++) access(1'b1, 2'd2, 32'(i * 4), 32'hC0DE_0000 + 32'(i), "fill i");
    for (int i = 0; i < DBYTES / 4; i++) access(1'b1, 2'd2, dtcm_base + 32'(i * 4), 32'hDA7A_0000 + 32'(i), "fill d");

    // R6 R7 lane writes and aligned reads in the instruction bank
    access(1'b1, 2'd2, 32'h10, 32'h1122_3344, "R6 word");
    for (int l = 0; l < 4; l++) access(1'b0, 2'd0, 32'h10 + 32'(l), 32'd0, "R7 byte rd");
    access(1'b1, 2'd0, 32'h12, 32'hFFFF_FFAB, "R6 byte lane2");
    access(1'b0, 2'd2, 32'h10, 32'd0, "R6 byte keeps others");
    access(1'b1, 2'd1, 32'h17, 32'h5566_7788, "R6 half ignores bit0");
    access(1'b0, 2'd2, 32'h14, 32'd0, "R6 half upper");
    access(1'b0, 2'd1, 32'h14, 32'd0, "R7 half lower");
    access(1'b0, 2'd1, 32'h16, 32'd0, "R7 half upper");
    access(1'b1, 2'd3, 32'h1B, 32'hCAFE_F00D, "R6 size3 word");
    access(1'b0, 2'd2, 32'h18, 32'd0, "R6 size3 read");

    // R4 mirroring across a window bigger than the bank
    access(1'b1, 2'd2, 32'h20 + IBYTES, 32'hBEEF_0001, "R4 mirror wr");
    access(1'b0, 2'd2, 32'h20, 32'd0, "R4 mirror rd");
    access(1'b0, 2'd2, 32'h20 + 3 * IBYTES, 32'd0, "R4 mirror rd hi");

    // R5 data bank offset and mirroring
    access(1'b1, 2'd0, dtcm_base + 32'h5, 32'h77, "R5 byte wr");
    access(1'b0, 2'd2, dtcm_base + 32'h4, 32'd0, "R5 word rd");
    access(1'b0, 2'd2, dtcm_base + DBYTES + 32'h4, 32'd0, "R5 mirror");
    dtcm_base = 32'h0080_0102; // unaligned base: offset bits come from addr - base
    access(1'b1, 2'd1, 32'h0080_0104, 32'h0000_9A9A, "R5 unaligned base wr");
    access(1'b0, 2'd2, 32'h0080_0102, 32'd0, "R5 unaligned base rd");
    dtcm_base = 32'h0080_0000;

    // R1 R2 window edges
    access(1'b0, 2'd2, 32'h7FFC, 32'd0, "R1 last itcm word");
    access(1'b0, 2'd0, 32'h8000, 32'd0, "R1 first past itcm");
    access(1'b0, 2'd0, dtcm_base - 1, 32'd0, "R2 below base");
    access(1'b0, 2'd0, dtcm_base + dtcm_size - 1, 32'd0, "R2 last byte");
    access(1'b0, 2'd0, dtcm_base + dtcm_size, 32'd0, "R2 past end");

    // R3 overlap: data window placed inside instruction window
    dtcm_base = 32'h0; dtcm_size = 32'h100;
    access(1'b1, 2'd2, 32'h40, 32'h0BAD_1DEA, "R3 overlap wr");
    dtcm_base = 32'h0080_0000; dtcm_size = 32'h4000;
    access(1'b0, 2'd2, 32'h40, 32'd0, "R3 went to itcm");
    access(1'b0, 2'd2, dtcm_base + 32'h40, 32'd0, "R3 dtcm untouched");

    // R1 size zero disables instruction bank
    itcm_size = 32'd0;
    access(1'b1, 2'd2, 32'h10, 32'h1234_5678, "R1 disabled wr");
    access(1'b0, 2'd2, 32'h0, 32'd0, "R1 disabled rd");
    itcm_size = 32'h8000;
    access(1'b0, 2'd2, 32'h10, 32'd0, "R1 store was not kept");

    // R2 all-ones base, zero size never hits; overflow-free top window
    dtcm_base = 32'hFFFF_FFFF; dtcm_size = 32'd0;
    access(1'b0, 2'd0, 32'hFFFF_FFFF, 32'd0, "R2 disabled");
    dtcm_base = 32'hFFFF_F000; dtcm_size = 32'h2000;
    access(1'b1, 2'd2, 32'hFFFF_FFFC, 32'h0F0F_1234, "R2 top wr");
    access(1'b0, 2'd2, 32'hFFFF_FFFC, 32'd0, "R2 top rd");
    itcm_size = 32'd0;
    access(1'b0, 2'd2, 32'h100, 32'd0, "R2 no wrap past top");

    // R8 stalled bus
    ext_ready = 1'b0;
    access(1'b1, 2'd1, 32'h0400_0180, 32'h0000_4F00, "R8 stalled");
    ext_ready = 1'b1;

    // R9 external load data forwarding
    ext_rvalid = 1'b1; ext_rdata = 32'hA5A5_5A5A; #1;
    chk(rsp_valid == 1'b1, "R9 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_rdata == 32'hA5A5_5A5A, "R9 rdata", rsp_rdata, 32'hA5A5_5A5A);
    @(negedge clk); ext_rvalid = 1'b0; #1;
    chk(rsp_valid == 1'b0, "R9 rvalid drop", 32'(rsp_valid), 32'd0);

    // R10 asynchronous assertion mid-run
    rst_n = 1'b0; #1;
    req_valid = 1'b1; req_addr = 32'h0100_0000; #1;
    chk(ext_valid == 1'b0, "R10 async reset blocks forward", 32'(ext_valid), 32'd0);
    req_valid = 1'b0;
    report();
  end
endmodule